// File: doc/BRIEF.md
# Memory Chain Enumeration and Sizing Engine

This engine brings up a serial chain of memory devices after power-up calibration is complete. It works as a bus master, issuing single-beat register and memory accesses through a request channel and taking read data back on a response channel. When started, it runs two passes over the chain.

In the first pass, it visits the devices one by one. For each device it assigns a temporary ID and enables the device. It then reads a type word that gives the device size, 1 MB or 2 MB. For each 2 MB device it also reads a vendor word and writes a row-timing value chosen from that vendor word. The size of every device found is kept in a small internal table. The first pass ends at the first position that returns a type word of zero, or when the table is full.

In the second pass, the engine re-initialises the whole chain with two broadcast writes. It then relocates the devices in the order they were found. Each device gets a final ID, register base and memory base, laid out so that all 2 MB devices sit below all 1 MB devices. After each move it issues dummy reads across the device's memory range. At the end the engine reports the device count, a mask with one bit per 2 MB device, and an overflow flag.

Both bus channels use valid/ready. A request is offered with `req_valid` and stays unchanged until `req_ready` accepts it. The engine never has more than one transaction in flight. After a read request is accepted, the engine holds `rsp_ready` high until `rsp_valid` delivers the data. A write gets no response. The fabric may stall either channel for any number of cycles; a stall changes only the timing, never the order or content of the transactions.

Top module: `mem_enum_engine`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `req_valid`, `rsp_ready`, `overflow`, `dev_count` and `multibank` are all 0.
- R2: Pass one handles chain position k (counted from 0) with this sequence:
  - write ID value 8·k to 0x03F0_8004;
  - write 0xC680_0000 to base+0xC, where base = 0x03F0_0000 + k·0x800;
  - read the type word at base+0x0.
- R3: Every register read, whether of a type word or a vendor word, is bracketed on the bus:
  - immediately before it, a write of 0x0000_2000 to 0x0430_0000;
  - immediately after it, a write of 0x0000_1000 to 0x0430_0000.
- R4: The type word is decoded as follows:
  - zero ends pass one and does not count a device;
  - any non-zero value counts a device;
  - the device is 2 MB when bit 1 of the word is set, and 1 MB otherwise.
- R5: After the type bracket of a 2 MB device, the engine performs a bracketed read of the vendor word at base+0x24. It then writes to base+0x18:
  - 0x101C_0A04 if the vendor word equals `cfg_vendor`;
  - `cfg_alt_timing` otherwise.
  Both configuration inputs are sampled only when a run starts, so changing them during a run has no effect.
- R6: `dev_count` equals the number of devices recorded. `multibank` starts at 0 and becomes (multibank<<1)|1 for each 2 MB device recorded.
- R7: If a non-zero type word arrives when MAX_DEV devices are already recorded, pass one ends, `overflow` is set, and that device is not counted.
- R8: Pass two begins with two writes, in this order:
  - 0xC480_0000 to 0x03F8_000C;
  - 0x8000_0000 to 0x03F8_0004.
- R9: Pass two visits the recorded devices in discovery order. Each device is placed with a write of its new ID to 0x03F0_8004, followed by a write of 0xC680_0000 to its new register base+0xC. Let N2 be the number of 2 MB devices.
  - The j-th 2 MB device gets ID j·0x0800_0000, register base 0x03F0_0000+j·0x800 and memory base j·0x20_0000.
  - The j-th 1 MB device gets ID N2·0x0800_0000 + j·0x0400_0000, register base 0x03F0_0000 + N2·0x800 + j·0x400 and memory base N2·0x20_0000 + j·0x10_0000.
- R10: After each placement the engine issues unbracketed reads at memory base plus an offset:
  - for a 2 MB device, offsets 0x0, 0x80000, 0x100000 and 0x180000, then the same four again;
  - for a 1 MB device, offsets 0x0 and 0x80000, then the same two again.
- R11: Request handshake rules:
  - a request held with `req_valid` high and `req_ready` low keeps its address, direction and data unchanged;
  - `rsp_ready` is high only while a read is outstanding, and never at the same time as `req_valid`.
- R12: Start and done behaviour:
  - `start` while idle begins a run, sets `busy` and clears `done`;
  - `start` while busy is ignored;
  - at the end of a run `done` rises, `busy` falls, and `done` and the results hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (honoured when idle) |
| cfg_vendor | input | 32 | Vendor word that selects the fixed timing value |
| cfg_alt_timing | input | 32 | Timing value written for any other vendor |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; held until next start |
| dev_count | output | $clog2(MAX_DEV+1) | Devices recorded |
| multibank | output | MAX_DEV | One set bit per 2 MB device, packed from bit 0 |
| overflow | output | 1 | Chain longer than the table |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Request accepted |
| req_we | output | 1 | 1 = write, 0 = read |
| req_addr | output | 32 | Request address |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Waiting for read data |
| rsp_rdata | input | 32 | Read data |

## Verification
The bench runs several chain patterns, each with a different purpose:
- An empty chain checks that pass one ends at once.
- Mixed 2 MB/1 MB orderings show whether the relocation really puts the large devices below the small ones, and whether the start addresses and strides of the two size classes are right.
- Chains of a single size expose stride errors within one class.
- Type words 3 and 5 separate decoding on bit 1 from matching whole values.
- Per-device vendor mismatches confirm that the timing value is chosen per device.
- A full table followed by one extra device, and a full table ended by a zero, pin down the overflow boundary.

Throughout every run the fabric stalls requests and delays read data at random, and the configuration inputs change and `start` pulses again mid-run. The full bus trace of each run must still match the trace worked out from the requirements.

// File: rtl/mde_pkg.sv
package mde_pkg;
  localparam int BUS_W = 32;

  localparam logic [BUS_W-1:0] ID_REG_ADDR     = 32'h03F0_8004;
  localparam logic [BUS_W-1:0] REG_SPACE_BASE  = 32'h03F0_0000;
  localparam logic [BUS_W-1:0] GATE_ADDR       = 32'h0430_0000;
  localparam logic [BUS_W-1:0] GATE_OPEN       = 32'h0000_2000;
  localparam logic [BUS_W-1:0] GATE_CLOSE      = 32'h0000_1000;
  localparam logic [BUS_W-1:0] ENABLE_WORD     = 32'hC680_0000;
  localparam logic [BUS_W-1:0] BC_CTRL_ADDR    = 32'h03F8_000C;
  localparam logic [BUS_W-1:0] BC_CTRL_WORD    = 32'hC480_0000;
  localparam logic [BUS_W-1:0] BC_ID_ADDR      = 32'h03F8_0004;
  localparam logic [BUS_W-1:0] BC_ID_WORD      = 32'h8000_0000;
  localparam logic [BUS_W-1:0] OFF_TYPE        = 32'h0000_0000;
  localparam logic [BUS_W-1:0] OFF_ENABLE      = 32'h0000_000C;
  localparam logic [BUS_W-1:0] OFF_ROWTIME     = 32'h0000_0018;
  localparam logic [BUS_W-1:0] OFF_VENDOR      = 32'h0000_0024;
  localparam logic [BUS_W-1:0] ROWTIME_MATCH   = 32'h101C_0A04;
  localparam logic [BUS_W-1:0] SCAN_ID_STEP    = 32'h0000_0008;
  localparam logic [BUS_W-1:0] SCAN_REG_STEP   = 32'h0000_0800;

  localparam int TICK_W           = 3;
  localparam int TICK_SPAN_LSB    = 19;
  localparam int TICK_READS_BIG   = 8;
  localparam int TICK_READS_SMALL = 4;

  function automatic logic [BUS_W-1:0] id_stride(input logic big);
    return big ? 32'h0800_0000 : 32'h0400_0000;
  endfunction
  function automatic logic [BUS_W-1:0] reg_stride(input logic big);
    return big ? 32'h0000_0800 : 32'h0000_0400;
  endfunction
  function automatic logic [BUS_W-1:0] mem_stride(input logic big);
    return big ? 32'h0020_0000 : 32'h0010_0000;
  endfunction

  typedef struct packed {
    logic             we;
    logic [BUS_W-1:0] addr;
    logic [BUS_W-1:0] wdata;
  } bus_cmd_t;

  typedef enum logic [4:0] {
    S_IDLE, S1_SETID, S1_EN, S1_GOPEN, S1_RDTYPE, S1_GCLOSE, S1_DECIDE,
    S1_VGOPEN, S1_RDVEN, S1_VGCLOSE, S1_ROWTIME,
    S2_BCCTRL, S2_BCID, S2_SETID, S2_EN, S2_TICKLE, S_FIN
  } seq_state_e;
endpackage

// File: rtl/mde_bus_port.sv
module mde_bus_port
  import mde_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  bus_cmd_t         cmd,
  output logic             cmd_done,
  output logic [BUS_W-1:0] cmd_rdata,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_we,
  output logic [BUS_W-1:0] req_addr,
  output logic [BUS_W-1:0] req_wdata,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [BUS_W-1:0] rsp_rdata
);
  typedef enum logic [1:0] {PS_IDLE, PS_REQ, PS_RSP} port_st_e;

  port_st_e st_q;
  bus_cmd_t held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= PS_IDLE;
      held_q <= '0;
    end else begin
      case (st_q)
        PS_IDLE: if (cmd_valid) begin
          held_q <= cmd;
          st_q   <= PS_REQ;
        end
        PS_REQ:  if (req_ready) st_q <= held_q.we ? PS_IDLE : PS_RSP;
        PS_RSP:  if (rsp_valid) st_q <= PS_IDLE;
        default: st_q <= PS_IDLE;
      endcase
    end
  end

  assign req_valid = (st_q == PS_REQ);
  assign req_we    = held_q.we;
  assign req_addr  = held_q.addr;
  assign req_wdata = held_q.wdata;
  assign rsp_ready = (st_q == PS_RSP);
  assign cmd_done  = (req_valid && req_ready && held_q.we) || (rsp_ready && rsp_valid);
  assign cmd_rdata = rsp_rdata;
endmodule

// File: rtl/mde_size_table.sv
module mde_size_table #(
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_big,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_big
);
  logic [DEPTH-1:0] big_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     big_q <= '0;
    else if (clear) big_q <= '0;
    else if (wr_en) big_q[wr_idx] <= wr_big;
  end

  assign rd_big = big_q[rd_idx];
endmodule

// File: rtl/mde_slot_cursor.sv
module mde_slot_cursor
  import mde_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             shift_small,
  input  logic             adv_valid,
  input  logic             adv_big,
  input  logic             sel_big,
  output logic [BUS_W-1:0] sel_id,
  output logic [BUS_W-1:0] sel_reg,
  output logic [BUS_W-1:0] sel_mem
);
  localparam int NCLS = 2;

  logic [NCLS-1:0][BUS_W-1:0] id_all, reg_all, mem_all;

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    localparam logic BIG = (c == 1);
    logic [BUS_W-1:0] id_q, reg_q, mem_q;
    logic             step, use_big;

    assign step    = (adv_valid && (adv_big == BIG)) || (!BIG && shift_small);
    assign use_big = BIG || shift_small;

    always_ff @(posedge clk) begin
      if (!rst_n || init) begin
        id_q  <= '0;
        reg_q <= REG_SPACE_BASE;
        mem_q <= '0;
      end else if (step) begin
        id_q  <= id_q  + id_stride(use_big);
        reg_q <= reg_q + reg_stride(use_big);
        mem_q <= mem_q + mem_stride(use_big);
      end
    end

    assign id_all[c]  = id_q;
    assign reg_all[c] = reg_q;
    assign mem_all[c] = mem_q;
  end

  assign sel_id  = id_all[sel_big];
  assign sel_reg = reg_all[sel_big];
  assign sel_mem = mem_all[sel_big];
endmodule

// File: rtl/mem_enum_engine.sv
module mem_enum_engine
  import mde_pkg::*;
#(
  parameter int MAX_DEV = 16,
  localparam int CW = $clog2(MAX_DEV + 1),
  localparam int IW = $clog2(MAX_DEV)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [BUS_W-1:0]   cfg_vendor,
  input  logic [BUS_W-1:0]   cfg_alt_timing,
  output logic               busy,
  output logic               done,
  output logic [CW-1:0]      dev_count,
  output logic [MAX_DEV-1:0] multibank,
  output logic               overflow,
  output logic               req_valid,
  input  logic               req_ready,
  output logic               req_we,
  output logic [BUS_W-1:0]   req_addr,
  output logic [BUS_W-1:0]   req_wdata,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic [BUS_W-1:0]   rsp_rdata
);
  localparam logic [CW-1:0] FULL  = CW'(MAX_DEV);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  seq_state_e         st_q;
  logic [CW-1:0]      cnt_q, idx_q;
  logic [MAX_DEV-1:0] mb_q;
  logic               ovf_q, done_q;
  logic [BUS_W-1:0]   vendor_q, alt_q, scan_id_q, scan_reg_q;
  logic               type_nz_q, type_big_q, vmatch_q;
  logic [TICK_W-1:0]  tk_q;

  logic             cmd_valid, op_done;
  bus_cmd_t         cmd;
  logic [BUS_W-1:0] op_rdata;
  logic             run_start, rec_en, cur_big, tick_last, adv_en;
  logic [1:0]       tick_sel;
  logic [BUS_W-1:0] cur_id, cur_reg, cur_mem;

  assign run_start = (st_q == S_IDLE) && start;
  assign rec_en    = (st_q == S1_DECIDE) && type_nz_q && (cnt_q != FULL);
  assign tick_last = cur_big ? (tk_q == TICK_W'(TICK_READS_BIG - 1))
                             : (tk_q == TICK_W'(TICK_READS_SMALL - 1));
  assign tick_sel  = cur_big ? tk_q[1:0] : {1'b0, tk_q[0]};
  assign adv_en    = (st_q == S2_TICKLE) && op_done && tick_last;

  mde_bus_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .cmd_done  (op_done),
    .cmd_rdata (op_rdata),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata)
  );

  mde_size_table #(.DEPTH(MAX_DEV)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (run_start),
    .wr_en  (rec_en),
    .wr_idx (cnt_q[IW-1:0]),
    .wr_big (type_big_q),
    .rd_idx (idx_q[IW-1:0]),
    .rd_big (cur_big)
  );

  mde_slot_cursor u_cursor (
    .clk         (clk),
    .rst_n       (rst_n),
    .init        (run_start),
    .shift_small (rec_en && type_big_q),
    .adv_valid   (adv_en),
    .adv_big     (cur_big),
    .sel_big     (cur_big),
    .sel_id      (cur_id),
    .sel_reg     (cur_reg),
    .sel_mem     (cur_mem)
  );

  always_comb begin
    cmd_valid = 1'b1;
    cmd       = '{we: 1'b1, addr: '0, wdata: '0};
    case (st_q)
      S1_SETID:   begin cmd.addr = ID_REG_ADDR;               cmd.wdata = scan_id_q;    end
      S1_EN:      begin cmd.addr = scan_reg_q + OFF_ENABLE;   cmd.wdata = ENABLE_WORD;  end
      S1_GOPEN,
      S1_VGOPEN:  begin cmd.addr = GATE_ADDR;                 cmd.wdata = GATE_OPEN;    end
      S1_GCLOSE,
      S1_VGCLOSE: begin cmd.addr = GATE_ADDR;                 cmd.wdata = GATE_CLOSE;   end
      S1_RDTYPE:  begin cmd.we = 1'b0; cmd.addr = scan_reg_q + OFF_TYPE;   end
      S1_RDVEN:   begin cmd.we = 1'b0; cmd.addr = scan_reg_q + OFF_VENDOR; end
      S1_ROWTIME: begin
        cmd.addr  = scan_reg_q + OFF_ROWTIME;
        cmd.wdata = vmatch_q ? ROWTIME_MATCH : alt_q;
      end
      S2_BCCTRL:  begin cmd.addr = BC_CTRL_ADDR;              cmd.wdata = BC_CTRL_WORD; end
      S2_BCID:    begin cmd.addr = BC_ID_ADDR;                cmd.wdata = BC_ID_WORD;   end
      S2_SETID:   begin cmd.addr = ID_REG_ADDR;               cmd.wdata = cur_id;       end
      S2_EN:      begin cmd.addr = cur_reg + OFF_ENABLE;      cmd.wdata = ENABLE_WORD;  end
      S2_TICKLE:  begin
        cmd.we   = 1'b0;
        cmd.addr = cur_mem + {{(BUS_W-TICK_SPAN_LSB-2){1'b0}}, tick_sel, {TICK_SPAN_LSB{1'b0}}};
      end
      default:    cmd_valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      mb_q       <= '0;
      ovf_q      <= 1'b0;
      done_q     <= 1'b0;
      vendor_q   <= '0;
      alt_q      <= '0;
      scan_id_q  <= '0;
      scan_reg_q <= REG_SPACE_BASE;
      type_nz_q  <= 1'b0;
      type_big_q <= 1'b0;
      vmatch_q   <= 1'b0;
      tk_q       <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          st_q       <= S1_SETID;
          done_q     <= 1'b0;
          cnt_q      <= '0;
          mb_q       <= '0;
          ovf_q      <= 1'b0;
          vendor_q   <= cfg_vendor;
          alt_q      <= cfg_alt_timing;
          scan_id_q  <= '0;
          scan_reg_q <= REG_SPACE_BASE;
        end
        S1_SETID:   if (op_done) st_q <= S1_EN;
        S1_EN:      if (op_done) st_q <= S1_GOPEN;
        S1_GOPEN:   if (op_done) st_q <= S1_RDTYPE;
        S1_RDTYPE:  if (op_done) begin
          type_nz_q  <= |op_rdata;
          type_big_q <= op_rdata[1];
          st_q       <= S1_GCLOSE;
        end
        S1_GCLOSE:  if (op_done) st_q <= S1_DECIDE;
        S1_DECIDE: begin
          if (!type_nz_q) begin
            st_q <= S2_BCCTRL;
          end else if (cnt_q == FULL) begin
            ovf_q <= 1'b1;
            st_q  <= S2_BCCTRL;
          end else begin
            cnt_q <= cnt_q + ONE_C;
            if (type_big_q) begin
              mb_q <= {mb_q[MAX_DEV-2:0], 1'b1};
              st_q <= S1_VGOPEN;
            end else begin
              scan_id_q  <= scan_id_q + SCAN_ID_STEP;
              scan_reg_q <= scan_reg_q + SCAN_REG_STEP;
              st_q       <= S1_SETID;
            end
          end
        end
        S1_VGOPEN:  if (op_done) st_q <= S1_RDVEN;
        S1_RDVEN:   if (op_done) begin
          vmatch_q <= (op_rdata == vendor_q);
          st_q     <= S1_VGCLOSE;
        end
        S1_VGCLOSE: if (op_done) st_q <= S1_ROWTIME;
        S1_ROWTIME: if (op_done) begin
          scan_id_q  <= scan_id_q + SCAN_ID_STEP;
          scan_reg_q <= scan_reg_q + SCAN_REG_STEP;
          st_q       <= S1_SETID;
        end
        S2_BCCTRL:  if (op_done) st_q <= S2_BCID;
        S2_BCID:    if (op_done) begin
          idx_q <= '0;
          st_q  <= (cnt_q == '0) ? S_FIN : S2_SETID;
        end
        S2_SETID:   if (op_done) st_q <= S2_EN;
        S2_EN:      if (op_done) begin
          tk_q <= '0;
          st_q <= S2_TICKLE;
        end
        S2_TICKLE:  if (op_done) begin
          if (tick_last) begin
            idx_q <= idx_q + ONE_C;
            st_q  <= ((idx_q + ONE_C) == cnt_q) ? S_FIN : S2_SETID;
          end else begin
            tk_q <= tk_q + TICK_W'(1);
          end
        end
        S_FIN: begin
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign done      = done_q;
  assign dev_count = cnt_q;
  assign multibank = mb_q;
  assign overflow  = ovf_q;
endmodule

// File: rtl/mem_enum_engine_chk.sv
module mem_enum_engine_chk #(
  parameter int MAX_DEV = 16,
  localparam int CW = $clog2(MAX_DEV + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic [CW-1:0]      dev_count,
  input logic [MAX_DEV-1:0] multibank,
  input logic               overflow,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_we,
  input logic [31:0]        req_addr,
  input logic [31:0]        req_wdata,
  input logic               rsp_ready
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_we) && $stable(req_wdata)));

  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !req_valid);

  p_quiet_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!req_valid && !rsp_ready));

  p_done_not_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_ovf_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (32'(dev_count) == MAX_DEV));

  p_mb_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(multibank) <= 32'(dev_count));

  p_mb_growth_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && (multibank != $past(multibank)))
      |-> (multibank == {$past(multibank[MAX_DEV-2:0]), 1'b1}));
endmodule

bind mem_enum_engine mem_enum_engine_chk #(.MAX_DEV(MAX_DEV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .dev_count (dev_count),
  .multibank (multibank),
  .overflow  (overflow),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_we    (req_we),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_ready (rsp_ready)
);

// File: tb/mem_enum_engine_bench.sv
`timescale 1ns/1ps
module mem_enum_engine_bench;
  localparam int MAXD = 16;
  localparam int CWB  = $clog2(MAXD + 1);
  localparam int LOGN = 512;
  localparam logic [31:0] VENDOR = 32'h0000_0A5C;
  localparam logic [31:0] ALT    = 32'h0A0B_0C0D;

  typedef struct packed {
    logic [63:0] codes;   // device k type word = codes[4k+:4]
    logic [3:0]  extra;   // type word of position 16
    logic [15:0] vmatch;  // device k vendor matches cfg
    logic [4:0]  exp_cnt;
    logic [15:0] exp_mb;
    logic        exp_ovf;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{64'h0,                   4'h0, 16'h0000, 5'd0,  16'h0000, 1'b0},
    '{64'h1212,                4'h0, 16'h0001, 5'd4,  16'h0003, 1'b0},
    '{64'h111,                 4'h0, 16'h0000, 5'd3,  16'h0000, 1'b0},
    '{64'h222,                 4'h0, 16'h0005, 5'd3,  16'h0007, 1'b0},
    '{64'h253,                 4'h0, 16'h0004, 5'd3,  16'h0003, 1'b0},
    '{64'h1212_1212_1212_1212, 4'h1, 16'h5555, 5'd16, 16'h00FF, 1'b1},
    '{64'h1111_1111_1111_1111, 4'h0, 16'h0000, 5'd16, 16'h0000, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [31:0]      cfg_vendor = VENDOR;
  logic [31:0]      cfg_alt_timing = ALT;
  logic             busy, done, overflow;
  logic [CWB-1:0]   dev_count;
  logic [MAXD-1:0]  multibank;
  logic             req_valid, req_we, rsp_ready;
  logic             req_ready = 1'b0;
  logic [31:0]      req_addr, req_wdata;
  logic             rsp_valid = 1'b0;
  logic [31:0]      rsp_rdata = '0;

  always #2.5 clk = ~clk;

  mem_enum_engine #(.MAX_DEV(MAXD)) u_mem_enum_engine (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_vendor(cfg_vendor), .cfg_alt_timing(cfg_alt_timing),
    .busy(busy), .done(done), .dev_count(dev_count),
    .multibank(multibank), .overflow(overflow),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // ---------------- bus responder and trace log ----------------
  vec_t        cur;
  logic        log_we   [LOGN];
  logic [31:0] log_addr [LOGN];
  logic [31:0] log_data [LOGN];
  int          n_log = 0;
  logic        ex_we    [LOGN];
  logic [31:0] ex_addr  [LOGN];
  logic [31:0] ex_data  [LOGN];
  int          n_exp = 0;

  logic [7:0]  lfsr = 8'h5A;
  bit          pend_rd = 1'b0;
  logic [31:0] pend_data = '0;
  int          dly = 0;

  function automatic logic [31:0] model_read(input logic [31:0] a);
    logic [31:0] rel;
    int k;
    if (a >= 32'h03F0_0000 && a < 32'h03F1_0000) begin
      rel = a - 32'h03F0_0000;
      k = int'(rel >> 11);
      if (rel[10:0] == 11'h000) return (k < 16) ? 32'(cur.codes[4*k +: 4]) : ((k == 16) ? 32'(cur.extra) : 32'h0);
      if (rel[10:0] == 11'h024) return (k < 16 && cur.vmatch[k]) ? VENDOR : ~VENDOR;
    end
    return 32'h0;
  endfunction

  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (rsp_valid) begin
      rsp_valid = 1'b0;
    end else if (pend_rd) begin
      if (dly == 0) begin
        rsp_valid = 1'b1;
        rsp_rdata = pend_data;
        pend_rd   = 1'b0;
      end else dly--;
    end
    req_ready = 1'b0;
    if (req_valid && !pend_rd && !rsp_valid && (lfsr[0] | lfsr[1])) begin
      req_ready = 1'b1;
      if (n_log < LOGN) begin
        log_we[n_log]   = req_we;
        log_addr[n_log] = req_addr;
        log_data[n_log] = req_wdata;
        n_log++;
      end
      if (!req_we) begin
        pend_rd   = 1'b1;
        pend_data = model_read(req_addr);
        dly       = int'(lfsr[3:2]);
      end
    end
  end

  // ---------------- expected trace from the requirements ----------------
  task automatic push(input logic we, input logic [31:0] a, input logic [31:0] d);
    if (n_exp < LOGN) begin
      ex_we[n_exp] = we; ex_addr[n_exp] = a; ex_data[n_exp] = we ? d : 32'h0; n_exp++;
    end
  endtask

  task automatic build_exp(input vec_t v);
    logic        big_l [MAXD];
    int          cnt = 0, nbig = 0, i2 = 0, i1 = 0;
    logic [3:0]  c;
    logic [31:0] base, id, rg, mem;
    n_exp = 0;
    for (int k = 0; k <= MAXD; k++) begin               // R2 R3 R4 R5 R7
      c    = (k < MAXD) ? v.codes[4*k +: 4] : v.extra;
      base = 32'h03F0_0000 + 32'(k) * 32'h800;
      push(1'b1, 32'h03F0_8004, 32'(k) * 32'h8);
      push(1'b1, base + 32'hC, 32'hC680_0000);
      push(1'b1, 32'h0430_0000, 32'h2000);
      push(1'b0, base, 32'h0);
      push(1'b1, 32'h0430_0000, 32'h1000);
      if (c == 4'h0 || cnt == MAXD) break;
      big_l[cnt] = c[1];
      cnt++;
      if (c[1]) begin
        nbig++;
        push(1'b1, 32'h0430_0000, 32'h2000);
        push(1'b0, base + 32'h24, 32'h0);
        push(1'b1, 32'h0430_0000, 32'h1000);
        push(1'b1, base + 32'h18, v.vmatch[k] ? 32'h101C_0A04 : ALT);
      end
    end
    push(1'b1, 32'h03F8_000C, 32'hC480_0000);           // R8
    push(1'b1, 32'h03F8_0004, 32'h8000_0000);
    for (int i = 0; i < cnt; i++) begin                 // R9 R10
      int reps, sets;
      if (big_l[i]) begin
        id = 32'(i2) * 32'h0800_0000; rg = 32'h03F0_0000 + 32'(i2) * 32'h800;
        mem = 32'(i2) * 32'h20_0000; i2++; reps = 8; sets = 4;
      end else begin
        id  = 32'(nbig) * 32'h0800_0000 + 32'(i1) * 32'h0400_0000;
        rg  = 32'h03F0_0000 + 32'(nbig) * 32'h800 + 32'(i1) * 32'h400;
        mem = 32'(nbig) * 32'h20_0000 + 32'(i1) * 32'h10_0000; i1++; reps = 4; sets = 2;
      end
      push(1'b1, 32'h03F0_8004, id);
      push(1'b1, rg + 32'hC, 32'hC680_0000);
      for (int r = 0; r < reps; r++) push(1'b0, mem + 32'(r % sets) * 32'h8_0000, 32'h0);
    end
  endtask

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", 64'(cyc), 64'd150000);
      summary();
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state while reset held
    chk(!busy && !done && !req_valid && !rsp_ready, "R1 control outputs in reset",
        {busy, done, req_valid, rsp_ready}, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !req_valid && !rsp_ready && !overflow, "R1 control outputs after reset",
        {busy, done, req_valid, rsp_ready, overflow}, 64'h0);
    chk(dev_count == '0 && multibank == '0, "R1 results after reset",
        {dev_count, multibank}, 64'h0);

    for (int vi = 0; vi < NV; vi++) begin
      int t;
      cur = VEC[vi];
      lfsr = 8'h5A ^ 8'(vi * 37);
      build_exp(cur);
      n_log = 0;
      cfg_vendor = VENDOR;
      cfg_alt_timing = ALT;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      // R12 a run starts: busy up, done cleared
      chk(busy && !done, "R12 busy after start", {busy, done}, 64'h2);
      repeat (8) @(negedge clk);
      // R5 configuration changes mid-run are ignored; R12 start while busy ignored
      cfg_vendor = ~VENDOR;
      cfg_alt_timing = 32'hDEAD_BEEF;
      if (busy) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      t = 0;
      while (!done && t < 20000) begin
        @(negedge clk);
        t++;
      end
      chk(done && !busy && !req_valid, "R12 done held idle at end", {done, busy, req_valid}, 64'h4);
      chk(dev_count == cur.exp_cnt[CWB-1:0], "R4 R6 device count", 64'(dev_count), 64'(cur.exp_cnt));
      chk(multibank == cur.exp_mb, "R6 multibank mask", 64'(multibank), 64'(cur.exp_mb));
      chk(overflow == cur.exp_ovf, "R7 overflow flag", 64'(overflow), 64'(cur.exp_ovf));
      begin
        int bad = -1;
        for (int j = 0; j < n_exp && j < n_log; j++) begin
          if (bad < 0 && (log_we[j] != ex_we[j] || log_addr[j] != ex_addr[j] ||
                          (ex_we[j] && log_data[j] != ex_data[j]))) bad = j;
        end
        chk(n_log == n_exp, "R2 R8 R9 R10 trace length", 64'(n_log), 64'(n_exp));
        if (bad >= 0)
          chk(1'b0, $sformatf("R2 R3 R5 R8 R9 R10 trace entry %0d", bad),
              {log_we[bad], log_addr[bad], log_data[bad]}[63:0],
              {ex_we[bad], ex_addr[bad], ex_data[bad]}[63:0]);
        else
          chk(1'b1, "R3 R5 R9 R10 trace content", 64'h0, 64'h0);
      end
      repeat (6) @(negedge clk);
      // R12 results and done hold while idle
      chk(done && dev_count == cur.exp_cnt[CWB-1:0], "R12 results held after done",
          {done, dev_count}, {1'b1, cur.exp_cnt});
    end

    finished = 1'b1;
    summary();
  end
endmodule